// File: doc/BRIEF.md
# Indirect Register Access Window

This block gives a host a way into a wide internal register space through a small window of 32 bytes. The window holds two 32-bit ports. The pointer port sits at byte offset 0x0 and the data port at byte offset 0x4. The host first loads a register address into the pointer port. Each later access to the data port is carried out on an internal register bus at that address. The bus is a simple request/ready master, and the host access stalls until the bus completes.

Before a data-port access is forwarded, the stored pointer is sorted into one of four regions. Only the lowest region reaches the register bus. The other three regions are refused, and so is any window offset other than the two ports. A refused access completes at once, with read data of zero and no bus activity. It also raises a single-cycle warning strobe that carries a 2-bit reason code and a flag for a bad window offset. All accesses are full 32-bit words, and data passes through unchanged in little-endian lane order.

Top module: `regwin_bridge`

## Requirements
- R1: After reset the stored pointer is 0, and `h_done`, `warn_stb` and `rb_req` are low.
- R2: A write to offset 0x0 stores all 32 bits of `h_wdata` as the pointer. A read of offset 0x0 returns the stored pointer unchanged. Either access completes with `h_done` one cycle after it is accepted.
- R3: A read of offset 0x4 with pointer < 0x1FFFF raises `rb_req` with `rb_we`=0 and `rb_addr` = pointer. `h_done` rises one cycle after the cycle in which `rb_rdy` is high, and `h_rdata` then equals the `rb_rdata` sampled with `rb_rdy`.
- R4: A write of offset 0x4 with pointer < 0x1FFFF raises `rb_req` with `rb_we`=1 and `rb_wdata` = `h_wdata`. The write completes on the same timing as R3, and `h_rdata` reads 0.
- R5: The pointer is classed by region. Below 0x1FFFF is accepted. From 0x1FFFF up to 0x7FFFE is code 1, undefined. From 0x7FFFF up to 0xFFFFE is code 2, flash. From 0xFFFFF upward is code 3, unknown. A refused data access reports its code on `warn_code`.
- R6: A refused data access never raises `rb_req`. A refused read returns 0 and a refused write changes nothing. Each completes one cycle after it is accepted.
- R7: An access to any offset other than 0x0 or 0x4 returns 0 and leaves the pointer unchanged. It completes one cycle after acceptance, with `warn_stb`=1, `warn_badoff`=1 and `warn_code`=0.
- R8: `warn_stb` is high for exactly one cycle, together with `h_done`, and only for refused accesses. Accepted accesses report `warn_code`=0.
- R9: While `rb_req` is high and `rb_rdy` is low, `rb_req`, `rb_addr`, `rb_we` and `rb_wdata` hold steady. A single host access produces exactly one bus request.
- R10: A data access issued straight after reset, with no pointer write, targets register address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_req | input | 1 | Host access request; held with its fields until `h_done` |
| h_we | input | 1 | Host write (1) or read (0) |
| h_off | input | 5 | Byte offset within the window |
| h_wdata | input | 32 | Host write data |
| h_done | output | 1 | One-cycle completion of the host access |
| h_rdata | output | 32 | Host read data, valid with `h_done` |
| rb_req | output | 1 | Register bus request |
| rb_we | output | 1 | Register bus write (1) or read (0) |
| rb_addr | output | 32 | Register bus address |
| rb_wdata | output | 32 | Register bus write data |
| rb_rdy | input | 1 | Register bus completion handshake |
| rb_rdata | input | 32 | Register bus read data, valid with `rb_rdy` |
| warn_stb | output | 1 | One-cycle strobe for a refused access |
| warn_code | output | 2 | Reason: 0 none, 1 undefined, 2 flash, 3 unknown |
| warn_badoff | output | 1 | Refusal was due to an undefined window offset |

## Verification
Accesses that stay inside the window, whether pointer-port accesses, refused data accesses or bad offsets, complete with `h_done` one cycle after the edge that accepts them. A forwarded access raises `rb_req` one cycle after acceptance and completes one cycle after the cycle in which `rb_rdy` is high. The bench drives on falling edges and counts falling edges from the request, so a forwarded access with a bus latency of L is due at falling edge L+2 and every other access at falling edge 1. It fails any completion that arrives on a different edge. The bench counts `rb_req` cycles against L+1, or against zero for a refused access. It also samples one falling edge after completion to confirm that the warning strobe has already dropped.

// File: rtl/regwin_pkg.sv
// Package: shared types for the indirect register window.
// Assumes: nothing; types only.
package regwin_pkg;
    // reason reported for a refused access
    typedef enum logic [1:0] {
        RC_NONE    = 2'd0,
        RC_UNDEF   = 2'd1,
        RC_FLASH   = 2'd2,
        RC_UNKNOWN = 2'd3
    } rej_code_t;

    // access sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_BUS  = 2'd1,
        SQ_DONE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/regwin_classify.sv
// Module: sorts a register pointer into accepted / undefined / flash / unknown.
// Assumes: limits ascend (LIM_REG < LIM_UNDEF < LIM_FLASH); purely combinational.
module regwin_classify
    import regwin_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter logic [ADDR_W-1:0] LIM_REG   = 'h1FFFF,
    parameter logic [ADDR_W-1:0] LIM_UNDEF = 'h7FFFF,
    parameter logic [ADDR_W-1:0] LIM_FLASH = 'hFFFFF
) (
    input  logic [ADDR_W-1:0] ptr,
    output rej_code_t         cls
);
    // region decode, lowest region first
    always_comb begin
        if (ptr < LIM_REG)        cls = RC_NONE;
        else if (ptr < LIM_UNDEF) cls = RC_UNDEF;
        else if (ptr < LIM_FLASH) cls = RC_FLASH;
        else                      cls = RC_UNKNOWN;
    end
endmodule

// File: rtl/regwin_ptr.sv
// Module: holds the register pointer written through the pointer port.
// Assumes: load is a single-cycle qualified write strobe.
module regwin_ptr #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] din,
    output logic [ADDR_W-1:0] q
);
    // pointer register, cleared to register 0 on reset
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= din;
    end
endmodule

// File: rtl/regwin_seq.sv
// Module: accepts host accesses, decodes the window offset, runs the
// register-bus handshake and produces completion and warning strobes.
// Assumes: host holds h_req and fields until h_done; DATA_W == ADDR_W.
module regwin_seq
    import regwin_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned OFF_W     = 5,
    parameter int unsigned ADDR_PORT = 0,
    parameter int unsigned DATA_PORT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_req,
    input  logic              h_we,
    input  logic [OFF_W-1:0]  h_off,
    input  logic [DATA_W-1:0] h_wdata,
    input  logic [ADDR_W-1:0] ptr_q,
    input  rej_code_t         cls,
    input  logic              rb_rdy,
    input  logic [DATA_W-1:0] rb_rdata,
    output logic              ptr_load,
    output logic              h_done,
    output logic [DATA_W-1:0] h_rdata,
    output logic              rb_req,
    output logic              rb_we,
    output logic [DATA_W-1:0] rb_wdata,
    output logic              warn_stb,
    output rej_code_t         warn_code,
    output logic              warn_badoff
);
    localparam logic [OFF_W-1:0] OFF_A = OFF_W'(ADDR_PORT);
    localparam logic [OFF_W-1:0] OFF_D = OFF_W'(DATA_PORT);

    seq_state_t st;
    logic       hit_a;
    logic       hit_d;

    // offset decode of the presented access
    assign hit_a    = (h_off == OFF_A);
    assign hit_d    = (h_off == OFF_D);
    // pointer write strobe, only when an access is accepted
    assign ptr_load = (st == SQ_IDLE) && h_req && hit_a && h_we;

    // sequencer: accept, forward or refuse, then complete for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= SQ_IDLE;
            h_done      <= 1'b0;
            h_rdata     <= '0;
            rb_req      <= 1'b0;
            rb_we       <= 1'b0;
            rb_wdata    <= '0;
            warn_stb    <= 1'b0;
            warn_code   <= RC_NONE;
            warn_badoff <= 1'b0;
        end else begin
            h_done      <= 1'b0;
            warn_stb    <= 1'b0;
            warn_code   <= RC_NONE;
            warn_badoff <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (h_req) begin
                        if (hit_a) begin
                            h_rdata <= h_we ? '0 : DATA_W'(ptr_q);
                            h_done  <= 1'b1;
                            st      <= SQ_DONE;
                        end else if (hit_d && cls == RC_NONE) begin
                            rb_req   <= 1'b1;
                            rb_we    <= h_we;
                            rb_wdata <= h_wdata;
                            st       <= SQ_BUS;
                        end else begin
                            h_rdata     <= '0;
                            h_done      <= 1'b1;
                            warn_stb    <= 1'b1;
                            warn_code   <= hit_d ? cls : RC_NONE;
                            warn_badoff <= !hit_d;
                            st          <= SQ_DONE;
                        end
                    end
                end
                SQ_BUS: begin
                    if (rb_rdy) begin
                        rb_req  <= 1'b0;
                        h_rdata <= rb_we ? '0 : rb_rdata;
                        h_done  <= 1'b1;
                        st      <= SQ_DONE;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // R9
    rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_req && !rb_rdy) |=> (rb_req && $stable(rb_we) && $stable(rb_wdata)));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_done |=> !h_done);
    // R8
    warn_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warn_stb |-> h_done);
    // R5
    code_needs_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_code != RC_NONE) |-> (warn_stb && !warn_badoff));
endmodule

// File: rtl/regwin_bridge.sv
// Module: top of the indirect register window; ties pointer, region
// classifier and access sequencer together.
// Assumes: full-word host accesses; register bus answers every request.
module regwin_bridge
    import regwin_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WIN_BYTES = 32,
    parameter int unsigned ADDR_PORT = 0,
    parameter int unsigned DATA_PORT = 4,
    parameter logic [ADDR_W-1:0] LIM_REG   = 'h1FFFF,
    parameter logic [ADDR_W-1:0] LIM_UNDEF = 'h7FFFF,
    parameter logic [ADDR_W-1:0] LIM_FLASH = 'hFFFFF,
    localparam int unsigned OFF_W = $clog2(WIN_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_req,
    input  logic              h_we,
    input  logic [OFF_W-1:0]  h_off,
    input  logic [DATA_W-1:0] h_wdata,
    output logic              h_done,
    output logic [DATA_W-1:0] h_rdata,
    output logic              rb_req,
    output logic              rb_we,
    output logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_wdata,
    input  logic              rb_rdy,
    input  logic [DATA_W-1:0] rb_rdata,
    output logic              warn_stb,
    output logic [1:0]        warn_code,
    output logic              warn_badoff
);
    logic [ADDR_W-1:0] ptr_q;
    logic              ptr_load;
    rej_code_t         cls;
    rej_code_t         code_q;

    regwin_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (ptr_load),
        .din  (ADDR_W'(h_wdata)),
        .q    (ptr_q)
    );

    regwin_classify #(
        .ADDR_W   (ADDR_W),
        .LIM_REG  (LIM_REG),
        .LIM_UNDEF(LIM_UNDEF),
        .LIM_FLASH(LIM_FLASH)
    ) u_cls (
        .ptr(ptr_q),
        .cls(cls)
    );

    regwin_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .OFF_W    (OFF_W),
        .ADDR_PORT(ADDR_PORT),
        .DATA_PORT(DATA_PORT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .h_req      (h_req),
        .h_we       (h_we),
        .h_off      (h_off),
        .h_wdata    (h_wdata),
        .ptr_q      (ptr_q),
        .cls        (cls),
        .rb_rdy     (rb_rdy),
        .rb_rdata   (rb_rdata),
        .ptr_load   (ptr_load),
        .h_done     (h_done),
        .h_rdata    (h_rdata),
        .rb_req     (rb_req),
        .rb_we      (rb_we),
        .rb_wdata   (rb_wdata),
        .warn_stb   (warn_stb),
        .warn_code  (code_q),
        .warn_badoff(warn_badoff)
    );

    // bus address is the live pointer; it cannot move during a transfer
    assign rb_addr   = ptr_q;
    assign warn_code = code_q;

    // R6
    bus_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_req |-> (cls == RC_NONE));
    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_req && !rb_rdy) |=> $stable(rb_addr));
    // R7
    badoff_no_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warn_badoff |-> (warn_stb && code_q == RC_NONE));
endmodule

// File: tb/regwin_bridge_tb_top.sv
module regwin_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_req = 1'b0, h_we = 1'b0;
    logic [4:0]  h_off = '0;
    logic [31:0] h_wdata = '0;
    logic        h_done;
    logic [31:0] h_rdata;
    logic        rb_req, rb_we;
    logic [31:0] rb_addr, rb_wdata;
    logic        rb_rdy = 1'b0;
    logic [31:0] rb_rdata = '0;
    logic        warn_stb, warn_badoff;
    logic [1:0]  warn_code;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] ptr_m = '0;
    logic [31:0] first_rb_addr;

    always #5 clk = ~clk;

    regwin_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_off(h_off),
        .h_wdata(h_wdata), .h_done(h_done), .h_rdata(h_rdata), .rb_req(rb_req),
        .rb_we(rb_we), .rb_addr(rb_addr), .rb_wdata(rb_wdata), .rb_rdy(rb_rdy),
        .rb_rdata(rb_rdata), .warn_stb(warn_stb), .warn_code(warn_code),
        .warn_badoff(warn_badoff)
    );

    function automatic logic [1:0] cls_of(input logic [31:0] a);
        if (a < 32'h1FFFF)      return 2'd0;
        else if (a < 32'h7FFFF) return 2'd1;
        else if (a < 32'hFFFFF) return 2'd2;
        else                    return 2'd3;
    endfunction

    task automatic chk(input bit ok, input string r, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", r, act, exp);
        end
    endtask

    // one host access with a responder holding rb_rdy off for lat cycles
    task automatic access(input bit we, input logic [4:0] off,
                          input logic [31:0] wd, input int lat,
                          output logic [31:0] rd);
        bit          is_a, is_d, valid, done;
        int          cyc, nreq;
        logic [31:0] bus_val, exp_rd;
        logic [1:0]  exp_code, got_code;
        bit          got_warn, got_bad;
        string       tag;
        is_a = (off == 5'd0);
        is_d = (off == 5'd4);
        valid = is_d && (cls_of(ptr_m) == 2'd0);
        tag = is_a ? "R2" : (!is_d ? "R7" : (valid ? (we ? "R4" : "R3") : "R6"));
        bus_val = $urandom;
        done = 0; cyc = 0; nreq = 0; rd = '0;
        got_warn = 0; got_bad = 0; got_code = '0;
        @(negedge clk);
        h_req = 1'b1; h_we = we; h_off = off; h_wdata = wd;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
            if (h_done) begin
                done = 1; rd = h_rdata;
                got_warn = warn_stb; got_code = warn_code; got_bad = warn_badoff;
            end else if (rb_req) begin
                if (nreq == 0) first_rb_addr = rb_addr;
                chk(rb_addr == ptr_m, tag, rb_addr, ptr_m);
                chk(rb_we == we, tag, 32'(rb_we), 32'(we));
                if (we) chk(rb_wdata == wd, tag, rb_wdata, wd);
                if (nreq == lat) begin rb_rdy = 1'b1; rb_rdata = bus_val; end
                nreq++;
            end
        end
        h_req = 1'b0; rb_rdy = 1'b0; rb_rdata = '0;
        // completion timing, in falling edges after the request
        chk(cyc == (valid ? lat + 2 : 1), tag, 32'(cyc), 32'(valid ? lat + 2 : 1));
        // R9 one request held lat+1 cycles, none for refused
        chk(nreq == (valid ? lat + 1 : 0), "R9", 32'(nreq), 32'(valid ? lat + 1 : 0));
        exp_rd = we ? 32'd0 : (is_a ? ptr_m : (valid ? bus_val : 32'd0));
        chk(rd == exp_rd, tag, rd, exp_rd);
        exp_code = (is_d && !valid) ? cls_of(ptr_m) : 2'd0;
        chk(got_code == exp_code, "R5", 32'(got_code), 32'(exp_code));
        chk(got_warn == !(is_a || valid), "R8", 32'(got_warn), 32'(!(is_a || valid)));
        chk(got_bad == (!is_a && !is_d), "R7", 32'(got_bad), 32'(!is_a && !is_d));
        if (is_a && we) ptr_m = wd;
        @(negedge clk);
        // R8 strobe lasts one cycle only
        chk(!h_done && !warn_stb, "R8", 32'({h_done, warn_stb}), 32'd0);
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] edges [8];
        void'($urandom(32'd4242));
        edges[0] = 32'h0001FFFE; edges[1] = 32'h0001FFFF;
        edges[2] = 32'h0007FFFE; edges[3] = 32'h0007FFFF;
        edges[4] = 32'h000FFFFE; edges[5] = 32'h000FFFFF;
        edges[6] = 32'hFFFFFFFF; edges[7] = 32'h00000000;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!h_done && !warn_stb && !rb_req, "R1", 32'({h_done, warn_stb, rb_req}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!h_done && !warn_stb && !rb_req, "R1", 32'({h_done, warn_stb, rb_req}), 32'd0);
        // R10 first data access after reset targets register 0
        first_rb_addr = 32'hDEADBEEF;
        access(1'b0, 5'd4, 32'd0, 1, rd);
        chk(first_rb_addr == 32'd0, "R10", first_rb_addr, 32'd0);
        // R1 pointer reads as zero
        access(1'b0, 5'd0, 32'd0, 0, rd);
        chk(rd == 32'd0, "R1", rd, 32'd0);
        // R5 region boundaries, read and write each
        for (int i = 0; i < 8; i++) begin
            access(1'b1, 5'd0, edges[i], 0, rd);
            access(1'b0, 5'd0, 32'd0, 0, rd);
            access(1'b0, 5'd4, 32'd0, i % 3, rd);
            access(1'b1, 5'd4, $urandom, 2, rd);
        end
        // R7 bad offsets must not touch the pointer
        access(1'b1, 5'd0, 32'h00001234, 0, rd);
        access(1'b1, 5'd8, 32'h00055555, 0, rd);
        access(1'b1, 5'd1, 32'h00066666, 0, rd);
        access(1'b0, 5'd31, 32'd0, 0, rd);
        access(1'b0, 5'd0, 32'd0, 0, rd);
        chk(rd == 32'h00001234, "R7", rd, 32'h00001234);
        // random mix
        for (int n = 0; n < 400; n++) begin
            int          r;
            logic [4:0]  off;
            logic [31:0] wd;
            r = $urandom % 8;
            off = (r < 3) ? 5'd0 : ((r < 6) ? 5'd4 : 5'($urandom));
            if (off == 5'd0 && ($urandom % 2) == 1)
                wd = edges[$urandom % 8] + 32'($urandom % 3) - 32'd1;
            else
                wd = $urandom;
            access(1'($urandom), off, wd, $urandom % 4, rd);
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule